// File: doc/BRIEF.md
# LIN Break Detector

This block watches a serial receive line for a LIN break: the line held low for longer than any legal character. It counts consecutive low samples, one per bit-period tick, and raises a sticky break flag once the run reaches a selectable length of 10 or 11 bit times. The block runs alongside the data receiver rather than inside it. A break is found whether the line was idle when it began or a character was already being received.

A small character tracker follows the line in the same way the receiver would, using 8 data bits and 1 stop bit. When a break begins with a start bit taken from idle, the whole character, stop position included, is sampled low. The receiver would read this as a zero byte with a framing error, and the block gives a one-cycle indication of that event. Software clears the flag with a strobe. An interrupt request follows the flag while interrupts are enabled.

Top module: `lin_break_watch`

## Requirements
- R1: The low-run count advances only on cycles where `bit_tick` is high and `rx` is sampled low. Any tick that samples `rx` high returns the count to zero. `rx` levels between ticks have no effect.
- R2: `len_sel`=0 selects a threshold of 10 low samples and `len_sel`=1 selects 11. `brk_flag` rises in the cycle after the tick on which the run reaches the threshold. It then stays high until it is cleared.
- R3: After the flag has been set for a run, that same run cannot set it again, even if the flag is cleared while `rx` stays low. A new break needs at least one high sample first.
- R4: A `flag_clr` strobe clears `brk_flag` in the next cycle. The clear wins over a set in the same cycle.
- R5: `brk_irq` is high exactly when `brk_flag` and `irq_en` are both high.
- R6: A low run that starts inside a character, after its start bit, is still detected as a break.
- R7: When the tracker is idle (it has seen a high sample) and a low sample starts a character, and all 10 samples of that character are low, `zero_fe` pulses for one cycle after the 10th sample. A run that starts mid-character never produces this pulse.
- R8: While `enable` is low, the count is held at zero and neither `brk_flag` nor `zero_fe` can be set. The tracker needs a high sample after re-enable before it can start a character.
- R9: After reset, `brk_flag`, `brk_irq` and `zero_fe` are low, and the tracker waits for a high sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Detector enable |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| rx | input | 1 | Serial receive line |
| len_sel | input | 1 | Threshold select: 0 = 10 bits, 1 = 11 bits |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear strobe for the break flag |
| brk_flag | output | 1 | Sticky break detected flag |
| brk_irq | output | 1 | Interrupt request |
| zero_fe | output | 1 | Pulse: idle-started break read as zero byte with framing error |

## Verification
`brk_flag` and `zero_fe` are registered, so each is due one clock after the sampling tick or clear strobe that causes it. `brk_irq` follows the flag and `irq_en` in the same cycle. The bench steps a behavioural model at each rising edge using the inputs held since the previous falling edge. It compares all three outputs at every falling edge, so every expected value falls in exactly the cycle named above. The stimulus covers the corner cases: clear and threshold on the same tick, low levels between ticks, and breaks that start mid-character or while the block is disabled.

// File: rtl/lin_break_watch.sv
module lin_break_watch #(
  parameter int LEN_SHORT  = 10,
  parameter int LEN_LONG   = 11,
  parameter int FRAME_BITS = 10,
  localparam int CW = $clog2(LEN_LONG + 1),
  localparam int PW = $clog2(FRAME_BITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_tick,
  input  logic rx,
  input  logic len_sel,
  input  logic irq_en,
  input  logic flag_clr,
  output logic brk_flag,
  output logic brk_irq,
  output logic zero_fe
);

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_WAIT} trk_t;

  logic [CW-1:0] run_q, run_d, thr;
  logic [PW-1:0] pos_q;
  trk_t          st_q;
  logic          sample, hit, stop_pos, fe_d;

  assign sample   = enable & bit_tick;
  assign thr      = len_sel ? CW'(LEN_LONG) : CW'(LEN_SHORT);
  assign stop_pos = (st_q == ST_FRAME) && (pos_q == PW'(FRAME_BITS - 1));

  always_comb begin
    if (!enable)                run_d = '0;
    else if (!bit_tick)         run_d = run_q;
    else if (rx)                run_d = '0;
    else if (run_q == CW'(LEN_LONG)) run_d = run_q;
    else                        run_d = run_q + CW'(1);
  end

  assign hit  = sample & ~rx & (run_d == thr) & (run_q != thr);
  assign fe_d = sample & stop_pos & ~rx & (run_d == CW'(FRAME_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      brk_flag <= 1'b0;
      zero_fe  <= 1'b0;
    end else begin
      run_q   <= run_d;
      zero_fe <= fe_d;
      if (flag_clr)  brk_flag <= 1'b0;
      else if (hit)  brk_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT;
      pos_q <= '0;
    end else if (!enable) begin
      st_q  <= ST_WAIT;
      pos_q <= '0;
    end else if (bit_tick) begin
      case (st_q)
        ST_IDLE: if (!rx) begin
          st_q  <= ST_FRAME;
          pos_q <= PW'(1);
        end
        ST_FRAME: if (stop_pos) begin
          st_q  <= rx ? ST_IDLE : ST_WAIT;
          pos_q <= '0;
        end else begin
          pos_q <= pos_q + PW'(1);
        end
        default: if (rx) st_q <= ST_IDLE;
      endcase
    end
  end

  assign brk_irq = brk_flag & irq_en;

endmodule

// File: rtl/lin_break_watch_chk.sv
module lin_break_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic bit_tick,
  input logic rx,
  input logic irq_en,
  input logic flag_clr,
  input logic brk_flag,
  input logic brk_irq,
  input logic zero_fe
);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag && !flag_clr |=> brk_flag);

  a_r1_set_needs_low_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_flag && !flag_clr && !(bit_tick && !rx) |=> !brk_flag);

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !brk_flag);

  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !brk_irq);

  a_r7_fe_single: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fe |=> !zero_fe);

  a_r8_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !brk_flag |=> !brk_flag && !zero_fe);

endmodule

bind lin_break_watch lin_break_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .bit_tick(bit_tick), .rx(rx),
  .irq_en(irq_en), .flag_clr(flag_clr), .brk_flag(brk_flag),
  .brk_irq(brk_irq), .zero_fe(zero_fe)
);

// File: tb/tb_lin_break_watch.sv
`timescale 1ns/1ps
module tb_lin_break_watch;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, bit_tick = 1'b0, rx = 1'b1, len_sel = 1'b0;
  logic irq_en = 1'b0, flag_clr = 1'b0;
  logic brk_flag, brk_irq, zero_fe;

  int errors = 0, checks = 0;
  string cur_req = "R9";
  bit finished = 1'b0;

  // reference model state
  int m_run = 0, m_mode = 2, m_cnt = 0;   // mode 0 idle, 1 in char, 2 await high
  bit m_flag = 0, m_fe = 0, m_armed = 1;

  always #2 clk = ~clk;

  lin_break_watch dut (.*);

  always @(posedge clk) begin
    bit need, t;
    if (!rst_n) begin
      m_run = 0; m_mode = 2; m_cnt = 0; m_flag = 0; m_fe = 0; m_armed = 1;
    end else begin
      t = enable && bit_tick;
      m_fe = 0;
      need = 0;
      if (!enable) begin
        m_run = 0; m_mode = 2; m_cnt = 0; m_armed = 1;
      end else if (t) begin
        if (rx) begin m_run = 0; m_armed = 1; end
        else begin
          m_run++;
          if (m_armed && m_run >= (len_sel ? 11 : 10)) begin need = 1; m_armed = 0; end
        end
        if (m_mode == 0) begin
          if (!rx) begin m_mode = 1; m_cnt = 1; end
        end else if (m_mode == 1) begin
          m_cnt++;
          if (m_cnt == 10) begin
            if (!rx && m_run == 10) m_fe = 1;
            m_mode = rx ? 0 : 2;
          end
        end else if (rx) m_mode = 0;
      end
      if (flag_clr) m_flag = 0;
      else if (need) m_flag = 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check(cur_req, "brk_flag", brk_flag, m_flag);
    check(cur_req, "brk_irq", brk_irq, m_flag && irq_en);
    check(cur_req, "zero_fe", zero_fe, m_fe);
  end

  task automatic send(bit v, int n, bit clr_last = 0);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        rx = v;
        bit_tick = (k == 0);
        flag_clr = clr_last && (i == n - 1) && (k == 0);
      end
    end
    @(negedge clk); #1; bit_tick = 0; flag_clr = 0;
  endtask

  task automatic clear();
    @(negedge clk); #1; flag_clr = 1;
    @(negedge clk); #1; flag_clr = 0;
  endtask

  initial begin
    #300000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "brk_flag in reset", brk_flag, 0);
    check("R9", "zero_fe in reset", zero_fe, 0);
    #1; rst_n = 1; enable = 1; irq_en = 1;
    cur_req = "R9"; send(1, 2);

    cur_req = "R7"; send(0, 12);          // idle break, 10-bit threshold
    check("R2", "flag after 10-bit break", brk_flag, 1);
    check("R5", "irq with flag", brk_irq, 1);
    send(1, 2); clear();

    cur_req = "R4"; len_sel = 1;
    send(0, 10); send(0, 1, 1);            // clear on threshold tick
    check("R4", "clear beats set", brk_flag, 0);
    cur_req = "R3"; send(0, 5);
    check("R3", "no re-set in same run", brk_flag, 0);
    send(1, 2);

    cur_req = "R2"; send(0, 10);
    check("R2", "10 lows under 11-bit select", brk_flag, 0);
    send(0, 1);
    check("R2", "11th low sets", brk_flag, 1);
    send(1, 2); clear(); len_sel = 0;

    cur_req = "R6"; send(0, 1); send(1, 2); send(0, 14);
    check("R6", "mid-char break", brk_flag, 1);
    send(1, 3); clear();

    cur_req = "R1"; send(0, 9); send(1, 1); send(0, 9);
    check("R1", "high sample resets run", brk_flag, 0);
    send(1, 2);
    @(negedge clk); #1; rx = 0;
    repeat (40) @(negedge clk);            // low, no ticks
    check("R1", "no count without tick", brk_flag, 0);
    #1; rx = 1; send(1, 2);

    cur_req = "R8"; enable = 0; send(0, 14);
    check("R8", "disabled no flag", brk_flag, 0);
    enable = 1; send(0, 12);
    send(1, 2); clear();

    cur_req = "R5"; irq_en = 0; send(0, 11);
    check("R5", "masked irq", brk_irq, 0);
    irq_en = 1; @(negedge clk);
    check("R5", "irq after unmask", brk_irq, 1);
    #1; send(1, 2); clear();
    repeat (4) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule